// File: doc/BRIEF.md
# Three-Wire Serial Word EEPROM Slave

This block is the device end of a three-wire serial EEPROM that stores 16-bit words. A host drives an active-low select, a serial clock and a serial data line. Every command starts with a 16-clock header made of a fixed start pattern, an operation field and an address. Reads return the addressed word on the data output and then keep streaming the words that follow it. Writes take a 16-bit word and then run a self-timed program cycle. During that cycle the ready/busy output is low, and an active write-control input can cut the cycle short.

All four serial inputs come in through two-flop synchronizers onto a fast system clock, and edges of the serial clock are found on that clock. The array is held in registers. The `WORDS` parameter picks 512 or 1024 words. The program time is set by `PROG_CYCLES`, a count of system clocks, so simulation can use a short cycle.

Top module: `eeprom_slave`

## Requirements
- R1: After reset, `ready` is 1, `dout_en` is 0 and writes are disabled, so a write frame starts no program cycle.
- R2: A header is 16 serial-clock rising edges, with data sampled from `di` on each rising edge. Bits 1-4 must be 1,0,1,0. For 1024 words, bits 5-6 are the operation (1,0 read; 0,1 write), bit 7 is A0, bit 8 is A1, and bits 9-16 are A2 to A9. For 512 words, bits 5-7 are the operation (1,0,0 read; 0,1,0 write), bit 8 is A0, and bits 9-16 are A1 to A8.
- R3: Header bits 5-8 equal to 0,0,1,1 enable writes, and 0,0,0,0 disables them. The address bits are ignored and the command takes effect on the 16th rising edge.
- R4: For a read, `dout` carries data bit D0 from the falling edge of the 16th clock. Each later falling edge presents the next bit, least significant first. `wc` has no effect on a read.
- R5: Further clocks in a read stream the next word. The address wraps from the top word to word 0.
- R6: A write takes 16 data bits, least significant first. On the 32nd rising edge `ready` goes low for exactly `PROG_CYCLES` system clocks, and the word is then stored.
- R7: A write frame received while writes are disabled, or with `wc` high at the 32nd rising edge, leaves `ready` high and leaves the array unchanged.
- R8: If `wc` is high during a program cycle, the cycle ends within two clocks and the word is not stored. This happens whatever the level of `cs_n`.
- R9: While `ready` is low, no command is accepted, including enable and disable.
- R10: Raising `cs_n` cancels any frame, so an unfinished write stores nothing. `dout_en` is 0 while `cs_n` is high.
- R11: After a write frame, if `cs_n` falls while the serial clock is low, `dout` drives the ready level (1 ready, 0 busy) until `cs_n` rises.
- R12: A header whose first four bits are not 1,0,1,0 is ignored for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| wc | input | 1 | Write control; high blocks or aborts programming |
| dout | output | 1 | Serial data out, or ready status |
| dout_en | output | 1 | Output enable for `dout` (0 means high impedance) |
| ready | output | 1 | 1 when idle, 0 during a program cycle |

## Verification
Each serial edge reaches the decoder three system clocks after it changes at the pin: two synchronizer stages and one edge-detect stage. The bench holds each serial-clock level for six system clocks and samples `dout` six clocks after a falling edge. A read bit is therefore already settled when it is taken. The length of the program cycle is counted from the sample point six clocks after the 32nd clock falls, and the expected count is `PROG_CYCLES + 3 - 12`, which accounts for the edge latency and the two half-periods already spent. Abort and status results are sampled a few clocks after `wc` or `cs_n` changes, which is past the same three-clock path.

// File: rtl/eeprom_slave.sv
module eeprom_slave #(
  parameter int WORDS       = 1024,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sk,
  input  logic di,
  input  logic wc,
  output logic dout,
  output logic dout_en,
  output logic ready
);
  localparam int AW   = $clog2(WORDS);
  localparam int TW   = $clog2(PROG_CYCLES + 1);
  localparam bit WIDE = (AW == 10);

  typedef enum logic [2:0] {M_IDLE, M_HDR, M_RD, M_WR, M_STAT} mode_t;

  logic [1:0] cs_sy, sk_sy, di_sy, wc_sy;
  logic       cs_q, sk_q;
  wire cs_s = cs_sy[1];
  wire sk_s = sk_sy[1];
  wire di_s = di_sy[1];
  wire wc_s = wc_sy[1];

  wire sk_rise = sk_s & ~sk_q & ~cs_s;
  wire sk_fall = ~sk_s & sk_q & ~cs_s;
  wire cs_fall = ~cs_s & cs_q;
  wire cs_rise = cs_s & ~cs_q;

  mode_t       mode;
  logic [14:0] hdr;
  logic [4:0]  cnt;
  logic [3:0]  rbit;
  logic [AW-1:0] raddr, waddr;
  logic [15:0] wdata;
  logic        wen, busy, stat_arm, rd_go, sq;
  logic [TW-1:0] tmr;
  logic [15:0] mem [WORDS];

  wire [15:0] hn = {hdr, di_s};
  wire [3:0]  f  = hn[11:8];
  logic [7:0] af;
  always_comb for (int i = 0; i < 8; i++) af[i] = hn[7-i];

  wire        start_ok = (hn[15:12] == 4'b1010);
  wire        is_rd    = WIDE ? (f[3:2] == 2'b10) : (f[3:1] == 3'b100);
  wire        is_wr    = WIDE ? (f[3:2] == 2'b01) : (f[3:1] == 3'b010);
  wire [9:0]  a10      = WIDE ? {af, f[0], f[1]} : {1'b0, af, f[0]};
  wire [AW-1:0] dec_addr = a10[AW-1:0];
  wire        commit   = busy & ~wc_s & (tmr == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy <= 2'b11; sk_sy <= '0; di_sy <= '0; wc_sy <= '0;
      cs_q  <= 1'b1;  sk_q  <= 1'b0;
    end else begin
      cs_sy <= {cs_sy[0], cs_n}; sk_sy <= {sk_sy[0], sk};
      di_sy <= {di_sy[0], di};   wc_sy <= {wc_sy[0], wc};
      cs_q  <= cs_s;             sk_q  <= sk_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= M_IDLE; hdr <= '0; cnt <= '0; rbit <= '0;
      raddr <= '0; waddr <= '0; wdata <= '0;
      wen <= 1'b0; busy <= 1'b0; stat_arm <= 1'b0; rd_go <= 1'b0; sq <= 1'b0;
      tmr <= '0;
    end else begin
      if (busy) begin
        if (wc_s || tmr == '0) busy <= 1'b0;
        else tmr <= tmr - 1'b1;
      end
      if (cs_rise) begin
        mode  <= M_IDLE;
        rd_go <= 1'b0;
        if (mode == M_STAT) stat_arm <= 1'b0;
      end else if (cs_fall) begin
        if (stat_arm && !sk_s) mode <= M_STAT;
        else if (busy) mode <= M_IDLE;
        else begin
          mode <= M_HDR; cnt <= '0; stat_arm <= 1'b0;
        end
      end else begin
        case (mode)
          M_HDR: if (sk_rise) begin
            hdr <= hn[14:0];
            cnt <= cnt + 5'd1;
            if (cnt == 5'd15) begin
              if (!start_ok) mode <= M_IDLE;
              else if (is_rd) begin
                mode <= M_RD; raddr <= dec_addr; rbit <= '0; rd_go <= 1'b0;
              end else if (is_wr) begin
                mode <= M_WR; waddr <= dec_addr;
              end else begin
                if (f == 4'b0011) wen <= 1'b1;
                if (f == 4'b0000) wen <= 1'b0;
                mode <= M_IDLE;
              end
            end
          end
          M_RD: if (sk_fall) begin
            sq    <= mem[raddr][rbit];
            rd_go <= 1'b1;
            rbit  <= rbit + 4'd1;
            if (rbit == 4'd15) raddr <= raddr + 1'b1;
          end
          M_WR: if (sk_rise) begin
            wdata <= {di_s, wdata[15:1]};
            cnt   <= cnt + 5'd1;
            if (cnt == 5'd31) begin
              mode     <= M_IDLE;
              stat_arm <= 1'b1;
              if (wen && !wc_s) begin
                busy <= 1'b1;
                tmr  <= TW'(PROG_CYCLES - 1);
              end
            end
          end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk)
    if (commit) mem[waddr] <= wdata;

  assign ready   = ~busy;
  assign dout    = (mode == M_STAT) ? ~busy : sq;
  assign dout_en = ~cs_s & ((mode == M_RD & rd_go) | (mode == M_STAT));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wc_s |=> !busy);
  p_start_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen) && !$past(wc_s));
  p_busy_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(mode inside {M_HDR, M_RD, M_WR}));
  p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> mode == M_IDLE && !dout_en);
  p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tmr < TW'(PROG_CYCLES));
endmodule

// File: tb/eeprom_slave_test.sv
module eeprom_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 6;
  localparam int PROG       = 200;
  localparam int TPROG      = PROG + 3 - 2 * H;

  logic clk = 0, rst_n = 0, cs_n = 1, sk = 0, di = 0, wc = 0;
  logic dout, dout_en, ready;
  int checks = 0, errors = 0;
  bit done = 0;

  eeprom_slave #(.WORDS(1024), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sk(sk), .di(di), .wc(wc),
    .dout(dout), .dout_en(dout_en), .ready(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic sel();   sk = 1; tick(H); cs_n = 0; tick(H); sk = 0; tick(H); endtask
  task automatic desel(); sk = 0; tick(H); cs_n = 1; tick(H); endtask
  task automatic bitc(logic b); di = b; tick(H); sk = 1; tick(H); sk = 0; tick(H); endtask
  task automatic hdr16(logic [15:0] v); for (int i = 15; i >= 0; i--) bitc(v[i]); endtask

  function automatic logic [15:0] mk(logic [1:0] op, logic [9:0] a);
    logic [15:0] v;
    v[15:12] = 4'b1010; v[11] = op[1]; v[10] = op[0]; v[9] = a[0]; v[8] = a[1];
    for (int i = 0; i < 8; i++) v[7-i] = a[2+i];
    return v;
  endfunction

  task automatic cmd(logic [3:0] f);
    sel(); hdr16({4'b1010, f, 8'h5A}); desel();
  endtask

  task automatic wr_frame(logic [9:0] a, logic [15:0] d);
    sel(); hdr16(mk(2'b01, a));
    for (int i = 0; i < 16; i++) bitc(d[i]);
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready && n < 4 * PROG) begin tick(1); n++; end
  endtask

  task automatic write_word(logic [9:0] a, logic [15:0] d, output int n);
    wr_frame(a, d);
    n = 0;
    while (!ready && n < 4 * PROG) begin tick(1); n++; end
    desel();
  endtask

  task automatic read2(logic [9:0] a, output logic [15:0] w0, output logic [15:0] w1);
    logic [15:0] w [2];
    sel(); hdr16(mk(2'b10, a));
    for (int j = 0; j < 2; j++)
      for (int i = 0; i < 16; i++) begin
        if (j != 0 || i != 0) bitc(1'b0);
        w[j][i] = dout;
        if (!dout_en) w[j][i] = 1'bx;
      end
    desel();
    w0 = w[0]; w1 = w[1];
  endtask

  task automatic t_reset();
    int n;
    chk(ready === 1'b1, "R1 ready after reset", ready, 1);
    chk(dout_en === 1'b0, "R1 dout_en after reset", dout_en, 0);
    write_word(10'd5, 16'hAAAA, n);
    chk(n == 0, "R1 write disabled after reset", n, 0);
  endtask

  task automatic t_write_read();
    int n; logic [15:0] a, b;
    cmd(4'b0011);
    write_word(10'h3A5, 16'h1234, n);
    chk(n == TPROG, "R6 program cycle length", n, TPROG);
    write_word(10'h3A6, 16'hBEEF, n);
    wc = 1;
    read2(10'h3A5, a, b);
    wc = 0;
    chk(a === 16'h1234, "R4 R2 read word with wc high", a, 16'h1234);
    chk(b === 16'hBEEF, "R5 sequential next word", b, 16'hBEEF);
  endtask

  task automatic t_wrap();
    int n; logic [15:0] a, b;
    write_word(10'h3FF, 16'hC001, n);
    write_word(10'h000, 16'h0DD0, n);
    read2(10'h3FF, a, b);
    chk(a === 16'hC001, "R5 top word", a, 16'hC001);
    chk(b === 16'h0DD0, "R5 wrap to word 0", b, 16'h0DD0);
  endtask

  task automatic t_wc_block();
    int n; logic [15:0] a, b;
    wc = 1;
    write_word(10'h3A5, 16'hFFFF, n);
    wc = 0;
    chk(n == 0, "R7 wc high blocks start", n, 0);
    read2(10'h3A5, a, b);
    chk(a === 16'h1234, "R7 word unchanged", a, 16'h1234);
  endtask

  task automatic t_abort();
    logic [15:0] a, b;
    wr_frame(10'h3A6, 16'hFFFF);
    chk(ready === 1'b0, "R8 program started", ready, 0);
    desel(); tick(20);
    wc = 1; tick(5);
    chk(ready === 1'b1, "R8 wc aborts with cs high", ready, 1);
    wc = 0; tick(2);
    read2(10'h3A5, a, b);
    chk(b === 16'hBEEF, "R8 aborted word unchanged", b, 16'hBEEF);
  endtask

  task automatic t_busy_lock();
    int n; logic [15:0] a, b;
    wr_frame(10'h010, 16'h4242);
    desel();
    cmd(4'b0000);
    wait_ready();
    write_word(10'h011, 16'h2424, n);
    chk(n == TPROG, "R9 disable ignored while busy", n, TPROG);
    read2(10'h010, a, b);
    chk(a === 16'h4242, "R9 first write stored", a, 16'h4242);
    chk(b === 16'h2424, "R9 second write stored", b, 16'h2424);
  endtask

  task automatic t_cancel();
    logic [15:0] a, b;
    sel(); hdr16(mk(2'b01, 10'h010));
    for (int i = 0; i < 8; i++) bitc(1'b1);
    desel();
    chk(ready === 1'b1, "R10 cancelled write no busy", ready, 1);
    chk(dout_en === 1'b0, "R10 dout off with cs high", dout_en, 0);
    read2(10'h010, a, b);
    chk(a === 16'h4242, "R10 cancelled write stores nothing", a, 16'h4242);
  endtask

  task automatic t_status();
    logic [15:0] a, b;
    wr_frame(10'h020, 16'h7777);
    desel();
    chk(dout_en === 1'b0, "R11 off before status select", dout_en, 0);
    cs_n = 0; tick(H);
    chk(dout_en === 1'b1 && dout === 1'b0, "R11 busy shown on dout", {dout_en, dout}, 2'b10);
    wait_ready(); tick(4);
    chk(dout === 1'b1, "R11 ready shown on dout", dout, 1);
    cs_n = 1; tick(H);
    chk(dout_en === 1'b0, "R11 status ends on deselect", dout_en, 0);
    read2(10'h020, a, b);
    chk(a === 16'h7777, "R11 status write stored", a, 16'h7777);
  endtask

  task automatic t_bad_start();
    logic [15:0] a, b; logic [15:0] v;
    v = mk(2'b01, 10'h020); v[15:12] = 4'b0110;
    sel(); hdr16(v);
    for (int i = 0; i < 16; i++) bitc(1'b0);
    chk(ready === 1'b1, "R12 bad start no busy", ready, 1);
    desel();
    read2(10'h020, a, b);
    chk(a === 16'h7777, "R12 word unchanged", a, 16'h7777);
  endtask

  task automatic t_disable();
    int n; logic [15:0] a, b;
    cmd(4'b0000);
    write_word(10'h020, 16'h0000, n);
    chk(n == 0, "R3 disable blocks write", n, 0);
    read2(10'h020, a, b);
    chk(a === 16'h7777, "R3 word unchanged after disable", a, 16'h7777);
  endtask

  initial begin
    tick(5); rst_n = 1; tick(5);
    t_reset();
    t_write_read();
    t_wrap();
    t_wc_block();
    t_abort();
    t_busy_lock();
    t_cancel();
    t_status();
    t_bad_start();
    t_disable();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule